// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees a wedged two-wire bus before the main bus controller takes over. A slave stopped in mid-byte can hold SDA low indefinitely. The sequencer clocks that slave out of its stuck state so the bus returns to idle. It works only through open-drain pull-down enables and the sampled line levels. During the whole sequence it holds the companion controller in soft reset. At the start it issues a one-cycle pulse that clears the controller's sticky status flags.

After a start pulse, the sequencer lets the sampled lines settle and checks whether both SDA and SCL read high. If they do, it finishes at once and sends no clock. If not, it keeps both lines released and repeats a loop: pull SCL low for a programmable number of clock cycles, release it, wait for the synchroniser to settle, and check the lines again. The loop ends when the bus is seen free or when the attempt limit is used up. When the sequence ends, the controller reset is removed, `done_o` pulses for one cycle, and `ok_o` reports whether the bus was freed.

Top module: `busfree_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, every output is 0, including `ok_o`.
- R2: A start pulse sampled while the block is idle gives, in the next cycle, `flags_clr_o` high for exactly one cycle, with `ctrl_rst_o` rising in that same cycle.
- R3: `ctrl_rst_o` stays high from that cycle to the end of the sequence. It falls in the cycle in which `done_o` is high, and `done_o` is high for exactly one cycle per sequence.
- R4: The bus counts as free only when both synchronised lines read high. If the bus is free at the first check, no SCL pulse is issued and `ok_o` becomes 1.
- R5: Each SCL pulse (`scl_pull_o` high) lasts `tick_period_i` cycles, or 1 cycle when `tick_period_i` is 0. `sda_pull_o` is never asserted, so SDA stays released.
- R6: While SDA is held low, the block issues SCL pulses one at a time. Each pulse is followed by a fresh check. The sequence stops with `ok_o` = 1 right after the pulse that makes the bus read free, so the pulse count equals the number of pulses the stuck device needs.
- R7: If the bus still reads busy after `MAX_TRIES` pulses, the sequence ends with `ok_o` = 0 and no further pulse is issued.
- R8: SCL held low from outside with SDA high counts as busy. Such a sequence issues `MAX_TRIES` pulses and ends with `ok_o` = 0.
- R9: A start pulse that arrives while a sequence is running has no effect. No second flag clear occurs, and the sequence ends with its own single `done_o` pulse and its own pulse count.
- R10: `ok_o` changes only in a cycle in which `done_o` is high, and it keeps its value after the sequence ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to run a recovery sequence |
| sda_i | input | 1 | Raw SDA line level |
| scl_i | input | 1 | Raw SCL line level |
| tick_period_i | input | TICK_W | SCL low time in clock cycles (0 acts as 1) |
| sda_pull_o | output | 1 | SDA pull-down enable (1 = drive low) |
| scl_pull_o | output | 1 | SCL pull-down enable (1 = drive low) |
| flags_clr_o | output | 1 | One-cycle pulse that clears the controller's status flags |
| ctrl_rst_o | output | 1 | Soft reset for the companion controller |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |
| ok_o | output | 1 | 1 if the bus was seen free, 0 if the attempt limit ran out |

## Verification
The bench builds the block with the default limit of 100 attempts, a 16-bit period field and a two-stage synchroniser. The SCL low time is driven at 0 to 20 cycles instead of the roughly 2000 cycles that 10 µs would take at 200 MHz. This short low time lets a run that exhausts all 100 attempts finish in a few thousand cycles. With it, the bench reaches the exact limit boundary (a stuck device that needs exactly 100 or 101 pulses), the zero-period clamp, an SCL stuck low, and a start request injected in the middle of a run.

// File: rtl/busfree_pkg.sv
package busfree_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CLR    = 2'd1,
    ST_SETTLE = 2'd2,
    ST_LOW    = 2'd3
  } seq_st_e;

  // Timer load for an SCL low phase: a period of 0 is treated as 1 cycle.
  function automatic logic [31:0] low_load(input logic [31:0] period);
    return (period == 32'd0) ? 32'd0 : period - 32'd1;
  endfunction

endpackage

// File: rtl/busfree_sync.sv
module busfree_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/busfree_timer.sv
module busfree_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/busfree_ctrl.sv
module busfree_ctrl
  import busfree_pkg::*;
#(
  parameter int TICK_W      = 16,
  parameter int MAX_TRIES   = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              free_i,
  input  logic [TICK_W-1:0] period_i,
  input  logic              tmr_zero_i,
  output logic              tmr_load_o,
  output logic [TICK_W-1:0] tmr_val_o,
  output logic              sda_pull_o,
  output logic              scl_pull_o,
  output logic              flags_clr_o,
  output logic              ctrl_rst_o,
  output logic              done_o,
  output logic              ok_o
);

  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [TRY_W-1:0]  TRY_LIMIT  = TRY_W'(MAX_TRIES);
  localparam logic [TICK_W-1:0] SETTLE_LEN = TICK_W'(SYNC_STAGES);

  seq_st_e          st_q;
  logic [TRY_W-1:0] tries_q;
  logic             at_limit;
  logic             check_now;
  logic [TICK_W-1:0] low_val;

  assign at_limit  = (tries_q == TRY_LIMIT);
  assign check_now = (st_q == ST_SETTLE) && tmr_zero_i;
  assign low_val   = TICK_W'(low_load(32'(period_i)));

  always_comb begin
    tmr_load_o = 1'b0;
    tmr_val_o  = SETTLE_LEN;
    unique case (st_q)
      ST_CLR:    tmr_load_o = 1'b1;
      ST_SETTLE: begin
        tmr_val_o = low_val;
        if (check_now && !free_i && !at_limit) tmr_load_o = 1'b1;
      end
      ST_LOW:    if (tmr_zero_i) tmr_load_o = 1'b1;
      default:   tmr_load_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      tries_q     <= '0;
      sda_pull_o  <= 1'b0;
      scl_pull_o  <= 1'b0;
      flags_clr_o <= 1'b0;
      ctrl_rst_o  <= 1'b0;
      done_o      <= 1'b0;
      ok_o        <= 1'b0;
    end else begin
      flags_clr_o <= 1'b0;
      done_o      <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q        <= ST_CLR;
            flags_clr_o <= 1'b1;
            ctrl_rst_o  <= 1'b1;
            tries_q     <= '0;
          end
        end
        ST_CLR: st_q <= ST_SETTLE;
        ST_SETTLE: begin
          if (check_now) begin
            if (free_i || at_limit) begin
              st_q       <= ST_IDLE;
              ctrl_rst_o <= 1'b0;
              done_o     <= 1'b1;
              ok_o       <= free_i;
            end else begin
              st_q       <= ST_LOW;
              sda_pull_o <= 1'b0;
              scl_pull_o <= 1'b1;
              tries_q    <= tries_q + 1'b1;
            end
          end
        end
        ST_LOW: begin
          if (tmr_zero_i) begin
            st_q       <= ST_SETTLE;
            scl_pull_o <= 1'b0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  scl_under_reset_chk: assert property (@(posedge clk) disable iff (rst)
    scl_pull_o |-> ctrl_rst_o);

  // R3
  done_drops_reset_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!ctrl_rst_o && $past(ctrl_rst_o)));

  // R2
  clear_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    flags_clr_o |-> (ctrl_rst_o && !$past(ctrl_rst_o)));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rst_o && start_i) |=> !flags_clr_o);

  // R10
  ok_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(ok_o));

  // R7
  try_bound_chk: assert property (@(posedge clk) disable iff (rst)
    tries_q <= TRY_LIMIT);

endmodule

// File: rtl/busfree_seq.sv
module busfree_seq #(
  parameter int TICK_W      = 16,
  parameter int MAX_TRIES   = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              sda_i,
  input  logic              scl_i,
  input  logic [TICK_W-1:0] tick_period_i,
  output logic              sda_pull_o,
  output logic              scl_pull_o,
  output logic              flags_clr_o,
  output logic              ctrl_rst_o,
  output logic              done_o,
  output logic              ok_o
);

  logic [1:0]        line_sync;
  logic              bus_free;
  logic              tmr_load;
  logic [TICK_W-1:0] tmr_val;
  logic              tmr_zero;

  busfree_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({sda_i, scl_i}),
    .q_o (line_sync)
  );

  assign bus_free = line_sync[1] & line_sync[0];

  busfree_timer #(.W(TICK_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  busfree_ctrl #(
    .TICK_W      (TICK_W),
    .MAX_TRIES   (MAX_TRIES),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .free_i      (bus_free),
    .period_i    (tick_period_i),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .sda_pull_o  (sda_pull_o),
    .scl_pull_o  (scl_pull_o),
    .flags_clr_o (flags_clr_o),
    .ctrl_rst_o  (ctrl_rst_o),
    .done_o      (done_o),
    .ok_o        (ok_o)
  );

endmodule

// File: tb/sim_busfree_seq.sv
`timescale 1ns/1ps
module sim_busfree_seq;

  localparam int TICK_W = 16;
  localparam int MAXT   = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [TICK_W-1:0] period = '0;
  logic sda_pull, scl_pull, flags_clr, ctrl_rst, done, ok;
  logic sda_line, scl_line;

  int need = 0;
  logic scl_stuck = 1'b0;
  int pulses = 0, cur_w = 0, werr = 0, clr_cnt = 0, done_cnt = 0, sda_bad = 0;
  int exp_w = 1;
  logic prev_pull = 1'b0;
  int checks = 0, fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  assign scl_line = !scl_pull && !scl_stuck;
  assign sda_line = !sda_pull && (pulses >= need);

  busfree_seq #(.TICK_W(TICK_W), .MAX_TRIES(MAXT), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .sda_i(sda_line), .scl_i(scl_line),
    .tick_period_i(period), .sda_pull_o(sda_pull), .scl_pull_o(scl_pull),
    .flags_clr_o(flags_clr), .ctrl_rst_o(ctrl_rst), .done_o(done), .ok_o(ok)
  );

  // Monitor: pulse widths and counts
  always @(negedge clk) begin
    if (scl_pull) cur_w++;
    else if (prev_pull) begin
      pulses++;
      if (cur_w != exp_w) werr++;
      cur_w = 0;
    end
    prev_pull = scl_pull;
    if (flags_clr) clr_cnt++;
    if (done) done_cnt++;
    if (sda_pull) sda_bad++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_pulses(input int n, input logic stuck);
    if (stuck || n > MAXT) return MAXT;
    return n;
  endfunction

  function automatic int exp_ok(input int n, input logic stuck);
    return (!stuck && n <= MAXT) ? 1 : 0;
  endfunction

  task automatic run_seq(input int n, input logic stuck, input int per, input bit inject);
    int okv;
    @(negedge clk);
    need = n; scl_stuck = stuck; period = TICK_W'(per);
    exp_w = (per == 0) ? 1 : per;
    pulses = 0; werr = 0; clr_cnt = 0; done_cnt = 0; cur_w = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R2: flag clear and controller reset one cycle after start
    chk("R2 flags_clr", int'(flags_clr), 1);
    chk("R2 ctrl_rst", int'(ctrl_rst), 1);
    if (inject) begin
      repeat (8) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done) @(negedge clk);
    chk("R3 ctrl_rst low at done", int'(ctrl_rst), 0);
    okv = int'(ok);
    @(negedge clk);
    chk("R3 done single", done_cnt, 1);
    chk("R6/R7/R8 pulse count", pulses, exp_pulses(n, stuck));
    chk("R4/R6/R7 ok", okv, exp_ok(n, stuck));
    chk("R5 pulse width", werr, 0);
    chk("R5 sda released", sda_bad, 0);
    chk(inject ? "R9 single flag clear" : "R2 single flag clear", clr_cnt, 1);
    repeat (5) @(negedge clk);
    chk("R10 ok held", int'(ok), exp_ok(n, stuck));
    chk("R3 reset released", int'(ctrl_rst), 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1 reset outputs", int'({sda_pull, scl_pull, flags_clr, ctrl_rst, done, ok}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", int'({sda_pull, scl_pull, flags_clr, ctrl_rst, done, ok}), 0);

    run_seq(0, 1'b0, 4, 1'b0);      // R4 already free
    run_seq(1, 1'b0, 0, 1'b0);      // R5 zero period, R6 one pulse
    run_seq(9, 1'b0, 3, 1'b0);      // R6 typical stuck byte
    run_seq(MAXT, 1'b0, 1, 1'b0);   // R6 exactly at the limit
    run_seq(MAXT + 1, 1'b0, 2, 1'b0); // R7 one over the limit
    run_seq(0, 1'b1, 2, 1'b0);      // R8 SCL stuck low
    run_seq(20, 1'b0, 5, 1'b1);     // R9 start during run
    for (int k = 0; k < 20; k++) begin
      int n   = int'($urandom_range(0, 110));
      int per = int'($urandom_range(0, 20));
      run_seq(n, 1'b0, per, ($urandom_range(0, 3) == 0));
    end
    finish_run();
  end

endmodule